// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank with Wakeup Request

This block is a bank of general-purpose I/O lines with a word-addressed register file. Every line can be set as an input or as a driven output. Each input line can watch for any mix of four conditions: low level, high level, rising edge and falling edge. An event on a line sets that line's bit in two separate status registers. Each status register has its own enable register, and each pair drives its own interrupt output, so two processors can each take the events they care about. A wakeup request output pulses when an enabled line has an event, but only if the configuration allows wakeup.

Software writes a register in one clock cycle through a plain strobe, address and data interface. Reads are combinational on the address. Set and clear alias addresses change single bits of the interrupt enables, the wakeup enable and the output data without a read-modify-write. Pin inputs pass through a two-flop synchronizer before detection. An edge on a pin therefore shows in the status registers three rising clock edges after the pin changes.

Top module: `gpio_dual_irq_bank`

## Requirements
- R1: After reset the register at 0x34 (1 = line is an input) reads all ones and pin_drive_en is all zeros. 0x1C, 0x2C, 0x18, 0x28, 0x40, 0x44, 0x48, 0x4C, 0x20 and 0x50 read zero. 0x30 reads 2, 0x00 reads 0x18 and 0x14 reads 0x01.
- R2: A low-to-high change on an input line whose bit is set in 0x48 sets that bit in both status registers (0x18 and 0x28) within three clock edges of the pin change.
- R3: A high-to-low change on an input line whose bit is set in 0x4C sets that bit in both status registers. A rising change on that line does not, unless its 0x48 bit is also set.
- R4: An input line whose bit is set in 0x44 and is high, or whose bit is set in 0x40 and is low, sets its status bits. A line whose 0x34 bit is 0 (output) never sets status.
- R5: irq_a is 1 exactly when some bit is set in both 0x18 and 0x1C. irq_b is 1 exactly when some bit is set in both 0x28 and 0x2C.
- R6: Writing 0x18 or 0x28 clears the bits written as 1. A level condition that is still true sets its bit again, so the bit reads back as 1.
- R7: Writing 0x64, 0x74 or 0x84 sets the written 1 bits of 0x1C, 0x2C or 0x20. Writing 0x60, 0x70 or 0x80 clears them. Reading an alias address returns the value of its base register.
- R8: pin_out follows the output data register 0x3C. 0x94 sets its bits, 0x90 clears them, and both read back 0x3C. pin_drive_en is the inverse of 0x34.
- R9: wake_pulse is high for one clock cycle when an event lands on a line enabled in 0x20, provided 0x10 bit 2 is 1 and 0x10 bits 4:3 are not both 0. No pulse occurs otherwise.
- R10: A write to 0x10 with bit 1 set returns every register to its R1 value. 0x10 then holds the written value ANDed with 0x1D. Any write to 0x10 stores the value ANDed with 0x1D.
- R11: Writes to 0x00, 0x14 and 0x38 have no effect. 0x38 reads the synchronized pin levels. 0x30 keeps only its low 3 bits.
- R12: 0x50 stores a full word and 0x54 stores 8 bits. Both are storage only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data for the pins |
| pin_drive_en | output | 32 | 1 = the line is driven as an output |
| irq_a | output | 1 | Interrupt from status/enable pair 1 |
| irq_b | output | 1 | Interrupt from status/enable pair 2 |
| wake_pulse | output | 1 | One-cycle wakeup request |

## Verification
Detection is tried on separate lines with one condition armed on each: rising only, falling only, high level, low level. One line also toggles in the direction it is not armed for, which separates edge polarity from plain activity. A level line is cleared while its level still holds, then again after the level is gone. This tells re-evaluated level status apart from edge status, which stays clear. The wakeup path is driven by events with the idle field at zero, with the line's wakeup enable cleared, and with every condition met. Only the last case may give a pulse, and that pulse must last one cycle.

// File: rtl/gdb_pkg.sv
// Shared constants for the dual-interrupt GPIO bank: register offsets,
// fixed read values and the reset value of the control register.
// Assumes word-aligned byte addresses on an 8-bit address bus.
package gdb_pkg;
    localparam int unsigned GDB_AW = 8;
    localparam int unsigned GDB_DW = 32;

    localparam logic [GDB_AW-1:0] OFS_REV      = 8'h00;
    localparam logic [GDB_AW-1:0] OFS_CFG      = 8'h10;
    localparam logic [GDB_AW-1:0] OFS_SYSSTAT  = 8'h14;
    localparam logic [GDB_AW-1:0] OFS_STAT1    = 8'h18;
    localparam logic [GDB_AW-1:0] OFS_EN1      = 8'h1C;
    localparam logic [GDB_AW-1:0] OFS_WAKEEN   = 8'h20;
    localparam logic [GDB_AW-1:0] OFS_STAT2    = 8'h28;
    localparam logic [GDB_AW-1:0] OFS_EN2      = 8'h2C;
    localparam logic [GDB_AW-1:0] OFS_CTRL     = 8'h30;
    localparam logic [GDB_AW-1:0] OFS_DIR      = 8'h34;
    localparam logic [GDB_AW-1:0] OFS_DIN      = 8'h38;
    localparam logic [GDB_AW-1:0] OFS_DOUT     = 8'h3C;
    localparam logic [GDB_AW-1:0] OFS_LVLLO    = 8'h40;
    localparam logic [GDB_AW-1:0] OFS_LVLHI    = 8'h44;
    localparam logic [GDB_AW-1:0] OFS_RISE     = 8'h48;
    localparam logic [GDB_AW-1:0] OFS_FALL     = 8'h4C;
    localparam logic [GDB_AW-1:0] OFS_DEBEN    = 8'h50;
    localparam logic [GDB_AW-1:0] OFS_DEBTIME  = 8'h54;
    localparam logic [GDB_AW-1:0] OFS_EN1_CLR  = 8'h60;
    localparam logic [GDB_AW-1:0] OFS_EN1_SET  = 8'h64;
    localparam logic [GDB_AW-1:0] OFS_EN2_CLR  = 8'h70;
    localparam logic [GDB_AW-1:0] OFS_EN2_SET  = 8'h74;
    localparam logic [GDB_AW-1:0] OFS_WAKE_CLR = 8'h80;
    localparam logic [GDB_AW-1:0] OFS_WAKE_SET = 8'h84;
    localparam logic [GDB_AW-1:0] OFS_DOUT_CLR = 8'h90;
    localparam logic [GDB_AW-1:0] OFS_DOUT_SET = 8'h94;

    localparam int unsigned      CFG_W      = 5;
    localparam logic [CFG_W-1:0] CFG_KEEP   = 5'h1D;
    localparam int unsigned      CFG_SRST   = 1;
    localparam int unsigned      CFG_WAKE   = 2;
    localparam int unsigned      CTRL_W     = 3;
    localparam logic [CTRL_W-1:0] CTRL_RST  = 3'd2;
    localparam int unsigned      DEBT_W     = 8;
    localparam logic [GDB_DW-1:0] REV_VALUE = 32'h18;
    localparam logic [GDB_DW-1:0] SYSSTAT_VALUE = 32'h01;
    localparam int unsigned      NUM_IRQ    = 2;
endpackage

// File: rtl/gdb_sync.sv
// Two-flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no bus coherency is implied.
module gdb_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gdb_detect.sv
// Per-line event detector. It flags rising and falling edges on the
// synchronized levels and flags the current high or low level.
// Only lines configured as inputs (dir bit 1) produce events.
// Assumes pins_s is already synchronized to clk.
module gdb_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lvl_lo,
    input  logic [W-1:0] lvl_hi,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev;
    logic [W-1:0] edge_hit;
    logic [W-1:0] level_hit;

    // Hold the last sampled level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= pins_s;
    end

    // Combine edge and level conditions, qualified by direction.
    always_comb begin
        edge_hit  = (pins_s & ~prev & rise_en) | (~pins_s & prev & fall_en);
        level_hit = (pins_s & lvl_hi) | (~pins_s & lvl_lo);
        evt       = dir & (edge_hit | level_hit);
    end
endmodule

// File: rtl/gdb_irq_chan.sv
// One interrupt channel: a sticky status register with write-1-to-clear,
// an enable register with direct, set and clear writes, and the
// interrupt output. Events in the same cycle as a clear win, so an
// active level condition re-asserts status at once.
// Assumes the write strobes are mutually exclusive per cycle.
module gdb_irq_chan #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] evt,
    input  logic         st_wr,
    input  logic         en_wr,
    input  logic         en_clr,
    input  logic         en_set,
    input  logic [W-1:0] wv,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         irq
);
    // Status: collect events, clear bits written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) status <= '0;
        else                    status <= (st_wr ? (status & ~wv) : status) | evt;
    end

    // Enable: direct write, or atomic set / clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) enable <= '0;
        else if (en_wr)         enable <= wv;
        else if (en_set)        enable <= enable | wv;
        else if (en_clr)        enable <= enable & ~wv;
    end

    // Interrupt output: any enabled pending bit.
    assign irq = |(status & enable);

    // R2: an event bit is set in status on the next cycle.
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt && !soft_rst) |=> ((status & $past(evt)) == $past(evt)));

    // R6: bits written as 1 are clear unless an event set them again.
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !soft_rst) |=> ((status & $past(wv) & ~$past(evt)) == '0));

    // R7: the set alias leaves every written bit at 1.
    assert_en_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set && !en_wr && !soft_rst) |=> ((enable & $past(wv)) == $past(wv)));

    // R7: the clear alias leaves every written bit at 0.
    assert_en_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && !en_wr && !en_set && !soft_rst) |=> ((enable & $past(wv)) == '0));

    // R5: the interrupt never stands without a pending status bit.
    assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

// File: rtl/gpio_dual_irq_bank.sv
// GPIO bank with a register file, two interrupt channels and a
// wakeup request. Writes take effect on the rising clock edge where
// bus_wr is high. Reads are combinational on bus_addr.
// Assumes NLINES <= GDB_DW and word-aligned addresses.
module gpio_dual_irq_bank
    import gdb_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [GDB_AW-1:0] bus_addr,
    input  logic [GDB_DW-1:0] bus_wdata,
    output logic [GDB_DW-1:0] bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_drive_en,
    output logic              irq_a,
    output logic              irq_b,
    output logic              wake_pulse
);
    localparam int unsigned IDLE_LO = CFG_WAKE + 1;

    logic [NLINES-1:0] wv;
    logic              soft_rst;
    logic [CFG_W-1:0]  cfg;
    logic [CTRL_W-1:0] ctrl;
    logic [NLINES-1:0] dir, lvl_lo, lvl_hi, rise_en, fall_en, wake_en, dout, deb_en;
    logic [DEBT_W-1:0] deb_time;
    logic [NLINES-1:0] pins_s;
    logic [NLINES-1:0] evt;
    logic [NUM_IRQ-1:0][NLINES-1:0] st_q;
    logic [NUM_IRQ-1:0][NLINES-1:0] en_q;
    logic [NUM_IRQ-1:0]             irq_v;
    logic              wake_hit, wake_hit_d;

    assign wv       = bus_wdata[NLINES-1:0];
    assign soft_rst = bus_wr && (bus_addr == OFS_CFG) && bus_wdata[CFG_SRST];

    gdb_sync #(.W(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pins_s)
    );

    gdb_detect #(.W(NLINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .pins_s(pins_s), .dir(dir),
        .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .rise_en(rise_en),
        .fall_en(fall_en), .evt(evt)
    );

    // One channel per interrupt output, each with its own offsets.
    for (genvar ch = 0; ch < NUM_IRQ; ch++) begin : g_chan
        localparam logic [GDB_AW-1:0] A_ST  = (ch == 0) ? OFS_STAT1   : OFS_STAT2;
        localparam logic [GDB_AW-1:0] A_EN  = (ch == 0) ? OFS_EN1     : OFS_EN2;
        localparam logic [GDB_AW-1:0] A_CLR = (ch == 0) ? OFS_EN1_CLR : OFS_EN2_CLR;
        localparam logic [GDB_AW-1:0] A_SET = (ch == 0) ? OFS_EN1_SET : OFS_EN2_SET;
        gdb_irq_chan #(.W(NLINES)) u_chan (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt(evt),
            .st_wr (bus_wr && (bus_addr == A_ST)),
            .en_wr (bus_wr && (bus_addr == A_EN)),
            .en_clr(bus_wr && (bus_addr == A_CLR)),
            .en_set(bus_wr && (bus_addr == A_SET)),
            .wv(wv), .status(st_q[ch]), .enable(en_q[ch]), .irq(irq_v[ch])
        );
    end

    assign irq_a = irq_v[0];
    assign irq_b = irq_v[1];

    // Configuration register: masked store on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cfg <= '0;
        else if (bus_wr && bus_addr == OFS_CFG)    cfg <= bus_wdata[CFG_W-1:0] & CFG_KEEP;
    end

    // Detection, direction, wakeup-enable, control and debounce storage.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl     <= CTRL_RST;
            dir      <= '1;
            lvl_lo   <= '0;
            lvl_hi   <= '0;
            rise_en  <= '0;
            fall_en  <= '0;
            wake_en  <= '0;
            deb_en   <= '0;
            deb_time <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL:     ctrl     <= bus_wdata[CTRL_W-1:0];
                OFS_DIR:      dir      <= wv;
                OFS_LVLLO:    lvl_lo   <= wv;
                OFS_LVLHI:    lvl_hi   <= wv;
                OFS_RISE:     rise_en  <= wv;
                OFS_FALL:     fall_en  <= wv;
                OFS_WAKEEN:   wake_en  <= wv;
                OFS_WAKE_SET: wake_en  <= wake_en | wv;
                OFS_WAKE_CLR: wake_en  <= wake_en & ~wv;
                OFS_DEBEN:    deb_en   <= wv;
                OFS_DEBTIME:  deb_time <= bus_wdata[DEBT_W-1:0];
                default:      ;
            endcase
        end
    end

    // Output data: direct write plus atomic set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else if (bus_wr) begin
            case (bus_addr)
                OFS_DOUT:     dout <= wv;
                OFS_DOUT_SET: dout <= dout | wv;
                OFS_DOUT_CLR: dout <= dout & ~wv;
                default:      ;
            endcase
        end
    end

    assign pin_out      = dout;
    assign pin_drive_en = ~dir;

    // Wakeup: qualify events, then emit one pulse per run of hits.
    assign wake_hit = cfg[CFG_WAKE] && (cfg[CFG_W-1:IDLE_LO] != '0) && ((evt & wake_en) != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_hit_d <= 1'b0;
            wake_pulse <= 1'b0;
        end else begin
            wake_hit_d <= wake_hit;
            wake_pulse <= wake_hit && !wake_hit_d;
        end
    end

    // Read multiplexer; alias addresses return their base register.
    always_comb begin
        case (bus_addr)
            OFS_REV:                              bus_rdata = REV_VALUE;
            OFS_CFG:                              bus_rdata = GDB_DW'(cfg);
            OFS_SYSSTAT:                          bus_rdata = SYSSTAT_VALUE;
            OFS_STAT1:                            bus_rdata = GDB_DW'(st_q[0]);
            OFS_STAT2:                            bus_rdata = GDB_DW'(st_q[1]);
            OFS_EN1, OFS_EN1_CLR, OFS_EN1_SET:    bus_rdata = GDB_DW'(en_q[0]);
            OFS_EN2, OFS_EN2_CLR, OFS_EN2_SET:    bus_rdata = GDB_DW'(en_q[1]);
            OFS_WAKEEN, OFS_WAKE_CLR, OFS_WAKE_SET: bus_rdata = GDB_DW'(wake_en);
            OFS_CTRL:                             bus_rdata = GDB_DW'(ctrl);
            OFS_DIR:                              bus_rdata = GDB_DW'(dir);
            OFS_DIN:                              bus_rdata = GDB_DW'(pins_s);
            OFS_DOUT, OFS_DOUT_CLR, OFS_DOUT_SET: bus_rdata = GDB_DW'(dout);
            OFS_LVLLO:                            bus_rdata = GDB_DW'(lvl_lo);
            OFS_LVLHI:                            bus_rdata = GDB_DW'(lvl_hi);
            OFS_RISE:                             bus_rdata = GDB_DW'(rise_en);
            OFS_FALL:                             bus_rdata = GDB_DW'(fall_en);
            OFS_DEBEN:                            bus_rdata = GDB_DW'(deb_en);
            OFS_DEBTIME:                          bus_rdata = GDB_DW'(deb_time);
            default:                              bus_rdata = '0;
        endcase
    end

    // R9: a wakeup pulse lasts a single cycle.
    assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R9: a pulse needs the wakeup enable bit of the configuration.
    assert_wake_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(cfg[CFG_WAKE]));

    // R10: a soft reset leaves the direction register all ones.
    assert_soft_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (dir == '1));
endmodule

// File: tb/tb_gpio_dual_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_dual_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_drive_en;
    logic        irq_a, irq_b, wake_pulse;

    int checks = 0;
    int fails = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_dual_irq_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_drive_en(pin_drive_en), .irq_a(irq_a),
        .irq_b(irq_b), .wake_pulse(wake_pulse)
    );

    // Count cycles where the wakeup output is high, sampled mid-cycle.
    always @(negedge clk) if (rst_n && wake_pulse) wake_cnt++;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, $sformatf("read 0x%02h", a), d, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1", 8'h34, 32'hFFFF_FFFF);
        check("R1", "pin_drive_en", pin_drive_en, 32'h0);
        rd_chk("R1", 8'h1C, 0); rd_chk("R1", 8'h2C, 0);
        rd_chk("R1", 8'h18, 0); rd_chk("R1", 8'h28, 0);
        rd_chk("R1", 8'h40, 0); rd_chk("R1", 8'h44, 0);
        rd_chk("R1", 8'h48, 0); rd_chk("R1", 8'h4C, 0);
        rd_chk("R1", 8'h20, 0); rd_chk("R1", 8'h50, 0);
        rd_chk("R1", 8'h30, 2); rd_chk("R1", 8'h00, 32'h18);
        rd_chk("R1", 8'h14, 32'h01);
        check("R1", "irq_a", irq_a, 0); check("R1", "irq_b", irq_b, 0);
    endtask

    task automatic t_rise();
        wr(8'h48, 32'h1);
        pin_in[0] = 1'b1;
        settle();
        rd_chk("R2", 8'h18, 32'h1);
        rd_chk("R2", 8'h28, 32'h1);
        check("R5", "irq_a off while disabled", irq_a, 0);
        wr(8'h1C, 32'h1);
        check("R5", "irq_a enabled", irq_a, 1);
        check("R5", "irq_b still disabled", irq_b, 0);
        wr(8'h18, 32'h1);
        rd_chk("R6", 8'h18, 32'h0);
        check("R5", "irq_a after clear", irq_a, 0);
        rd_chk("R6", 8'h28, 32'h1);
        wr(8'h28, 32'h1);
        rd_chk("R6", 8'h28, 32'h0);
        wr(8'h1C, 32'h0);
    endtask

    task automatic t_fall();
        wr(8'h4C, 32'h2);
        pin_in[1] = 1'b1;
        settle();
        rd_chk("R3", 8'h18, 32'h0);
        pin_in[1] = 1'b0;
        settle();
        rd_chk("R3", 8'h18, 32'h2);
        rd_chk("R3", 8'h28, 32'h2);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        wr(8'h44, 32'h4);
        pin_in[2] = 1'b1;
        settle();
        rd_chk("R4", 8'h18, 32'h4);
        wr(8'h18, 32'h4);
        rd_chk("R6", 8'h18, 32'h4);
        pin_in[2] = 1'b0;
        settle();
        wr(8'h18, 32'h4);
        rd_chk("R6", 8'h18, 32'h0);
        wr(8'h44, 32'h0);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h40, 32'h8);
        settle();
        rd_chk("R4", 8'h18, 32'h8);
        wr(8'h34, ~32'h8);
        wr(8'h18, 32'hFFFF_FFFF);
        settle();
        rd_chk("R4", 8'h18, 32'h0);
        wr(8'h40, 32'h0);
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
    endtask

    task automatic t_alias();
        wr(8'h64, 32'h5);
        rd_chk("R7", 8'h1C, 32'h5);
        rd_chk("R7", 8'h60, 32'h5);
        rd_chk("R7", 8'h64, 32'h5);
        wr(8'h60, 32'h1);
        rd_chk("R7", 8'h1C, 32'h4);
        wr(8'h74, 32'hF0);
        wr(8'h70, 32'h30);
        rd_chk("R7", 8'h2C, 32'hC0);
        wr(8'h84, 32'h3);
        wr(8'h80, 32'h1);
        rd_chk("R7", 8'h20, 32'h2);
        rd_chk("R7", 8'h84, 32'h2);
    endtask

    task automatic t_dout();
        wr(8'h3C, 32'hA5);
        check("R8", "pin_out after write", pin_out, 32'hA5);
        wr(8'h94, 32'h100);
        check("R8", "pin_out after set", pin_out, 32'h1A5);
        wr(8'h90, 32'h5);
        check("R8", "pin_out after clear", pin_out, 32'h1A0);
        rd_chk("R8", 8'h90, 32'h1A0);
        wr(8'h34, 32'hFFFF_0000);
        check("R8", "pin_drive_en", pin_drive_en, 32'h0000_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
    endtask

    task automatic t_wake();
        int base;
        wr(8'h10, 32'h04);
        base = wake_cnt;
        pin_in[1] = 1'b1; settle();
        pin_in[1] = 1'b0; settle();
        check("R9", "no pulse with idle field zero", wake_cnt - base, 0);
        wr(8'h10, 32'h0C);
        rd_chk("R10", 8'h10, 32'h0C);
        base = wake_cnt;
        pin_in[1] = 1'b1; settle();
        pin_in[1] = 1'b0; settle();
        check("R9", "one-cycle pulse", wake_cnt - base, 1);
        base = wake_cnt;
        pin_in[0] = 1'b0; settle();
        pin_in[0] = 1'b1; settle();
        check("R9", "no pulse on line without wakeup enable", wake_cnt - base, 0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
    endtask

    task automatic t_readonly();
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h0);
        wr(8'h38, 32'hFFFF_FFFF);
        rd_chk("R11", 8'h00, 32'h18);
        rd_chk("R11", 8'h14, 32'h01);
        rd_chk("R11", 8'h38, pin_in);
        wr(8'h30, 32'hFF);
        rd_chk("R11", 8'h30, 32'h7);
        wr(8'h50, 32'h1234_5678);
        rd_chk("R12", 8'h50, 32'h1234_5678);
        wr(8'h54, 32'h1FF);
        rd_chk("R12", 8'h54, 32'hFF);
    endtask

    task automatic t_soft();
        wr(8'h1C, 32'hF);
        wr(8'h34, 32'h0000_00FF);
        wr(8'h10, 32'h1F);
        rd_chk("R10", 8'h10, 32'h1D);
        rd_chk("R10", 8'h1C, 32'h0);
        rd_chk("R10", 8'h34, 32'hFFFF_FFFF);
        rd_chk("R10", 8'h30, 32'h2);
        rd_chk("R10", 8'h50, 32'h0);
        rd_chk("R10", 8'h20, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_level();
        t_alias();
        t_dout();
        t_wake();
        t_readonly();
        t_soft();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule